// File: doc/BRIEF.md
# Swizzled Source Operand Fetch

This block delivers one four-lane source operand per request to a vector shading datapath. A 7-bit raw source index names a register in one of three banks: sixteen input registers, sixteen temporaries and ninety-six constants. When the index names a constant, a signed offset taken from one of three address registers can be added to it. The offset is dropped if it falls outside the signed byte range, and the sum wraps modulo 128. A wrapped index beyond the last constant yields a vector of 1.0 in every lane.

The fetched vector then passes through a per-lane swizzle and an optional sign inversion. The result is registered and presented one cycle after the request. Storage is modelled as plain arrays, loaded through a simple write port. Each lane is a 24-bit float: sign in bit 23, a 7-bit exponent in bits 22:16 and a 16-bit mantissa in bits 15:0, so 1.0 is 0x3F0000. In every 96-bit vector, lane k occupies bits 24k+23:24k, and lane 0 is component x.

A two-state controller drives the output side. ST_IDLE holds the last result with the output strobe low. The transition LOAD_REQ (request valid) enters ST_SHOW and captures the new result. In ST_SHOW the strobe is high. The transition CHAIN_REQ (another request) stays in ST_SHOW and captures again. The transition DRAIN (no request) returns to ST_IDLE.

Top module: `srcop_fetch`

## Requirements
- R1: While reset is asserted, and right after it, `out_valid` is 0 and `out_vec` is all zeros.
- R2: A request accepted on a clock edge produces `out_valid`=1 and its result on `out_vec` after exactly one edge. Without a request, `out_valid` is 0 after the next edge and `out_vec` keeps its last value.
- R3: The raw source index maps to banks as follows: 0x00 to 0x0F select input registers 0 to 15, 0x10 to 0x1F select temporaries 0 to 15, and 0x20 to 0x7F select constants 0 to 95.
- R4: Output lane k takes the source component coded by `req_swz` bits [7-2k:6-2k], where 0=x, 1=y, 2=z and 3=w. So 0x1B is the identity, 0x55 broadcasts y and 0xE4 reverses the components.
- R5: For a constant, `req_isel` picks the signed offset: 0 gives none, 1 gives `addr_x`, 2 gives `addr_y` and 3 gives `addr_loop`. The offset is added to the constant number, and a negative offset moves downward.
- R6: For input and temporary registers the offset is ignored, whatever `req_isel` and the address registers hold.
- R7: An offset below -128 or above 127 is replaced by 0.
- R8: The constant number plus the offset is taken modulo 128 (masked to 7 bits) before it is used.
- R9: If that masked constant number exceeds 95, every lane is 1.0 (0x3F0000) before negation.
- R10: When `req_neg` is 1, bit 23 of every lane is inverted after swizzling, including in the all-1.0 case. No other bit changes.
- R11: A write with `wr_bank`=3, or with `wr_idx` not below the size of the chosen bank, changes no register. Bank codes are 0 for inputs, 1 for temporaries and 2 for constants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_bank | input | 2 | Write bank: 0 input, 1 temporary, 2 constant |
| wr_idx | input | 7 | Register number within the bank |
| wr_vec | input | 96 | Four-lane write data |
| req_valid | input | 1 | Fetch request |
| req_src | input | 7 | Raw source index |
| req_isel | input | 2 | Offset source select |
| req_swz | input | 8 | Swizzle selector |
| req_neg | input | 1 | Negate after swizzle |
| addr_x | input | 10 | Address register x, signed |
| addr_y | input | 10 | Address register y, signed |
| addr_loop | input | 10 | Loop counter, signed |
| out_valid | output | 1 | Result strobe |
| out_vec | output | 96 | Fetched four-lane operand |

## Verification
The properties assume that the request fields and address registers are stable across the edge on which `req_valid` is sampled. They also assume that no write targets the register being fetched on that same edge. The bench drives every input on the falling edge. It separates the loading writes from the fetches, so no read ever races a write. The wrap and out-of-range cases use fixed address values chosen to land on the boundaries at -128, 127, 95 and 96.

// File: rtl/srcop_pkg.sv
package srcop_pkg;

    typedef enum logic [1:0] {
        BANK_IN    = 2'd0,
        BANK_TMP   = 2'd1,
        BANK_CONST = 2'd2,
        BANK_NONE  = 2'd3
    } bank_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } fetch_state_e;

endpackage

// File: rtl/srcop_locate.sv
module srcop_locate #(
    parameter int SRC_W     = 7,
    parameter int OFS_W     = 10,
    parameter int NUM_CONST = 96,
    parameter int BANK_REGS = 16
) (
    input  logic [SRC_W-1:0]       src,
    input  logic [1:0]             isel,
    input  logic signed [OFS_W-1:0] ofs_x,
    input  logic signed [OFS_W-1:0] ofs_y,
    input  logic signed [OFS_W-1:0] ofs_loop,
    output srcop_pkg::bank_e       bank,
    output logic [SRC_W-1:0]       reg_idx,
    output logic                   force_ones
);
    import srcop_pkg::*;

    localparam logic [SRC_W-1:0] TMP_START   = SRC_W'(BANK_REGS);
    localparam logic [SRC_W-1:0] CONST_START = SRC_W'(2 * BANK_REGS);
    localparam logic [SRC_W-1:0] CONST_LAST  = SRC_W'(NUM_CONST - 1);

    logic signed [OFS_W-1:0] raw_ofs;
    logic                    in_byte;
    logic [SRC_W-1:0]        ofs_used;
    logic [SRC_W-1:0]        const_num;
    logic [SRC_W-1:0]        wrapped;

    always_comb begin
        unique case (isel)
            2'd1:    raw_ofs = ofs_x;
            2'd2:    raw_ofs = ofs_y;
            2'd3:    raw_ofs = ofs_loop;
            default: raw_ofs = '0;
        endcase
        in_byte   = (raw_ofs >= -OFS_W'(128)) && (raw_ofs <= OFS_W'(127));
        ofs_used  = in_byte ? raw_ofs[SRC_W-1:0] : '0;
        const_num = src - CONST_START;
        wrapped   = const_num + ofs_used;
    end

    always_comb begin
        force_ones = 1'b0;
        if (src < TMP_START) begin
            bank    = BANK_IN;
            reg_idx = src - '0;
        end else if (src < CONST_START) begin
            bank    = BANK_TMP;
            reg_idx = src - TMP_START;
        end else begin
            bank       = BANK_CONST;
            reg_idx    = wrapped;
            force_ones = wrapped > CONST_LAST;
        end
    end

endmodule

// File: rtl/srcop_regfile.sv
module srcop_regfile #(
    parameter int VEC_W     = 96,
    parameter int IDX_W     = 7,
    parameter int NUM_IN    = 16,
    parameter int NUM_TMP   = 16,
    parameter int NUM_CONST = 96
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  srcop_pkg::bank_e     wr_bank,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [VEC_W-1:0]     wr_vec,
    input  srcop_pkg::bank_e     rd_bank,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [VEC_W-1:0]     rd_vec
);
    import srcop_pkg::*;

    localparam logic [IDX_W-1:0] IN_LIM    = IDX_W'(NUM_IN);
    localparam logic [IDX_W-1:0] TMP_LIM   = IDX_W'(NUM_TMP);
    localparam logic [IDX_W-1:0] CONST_LIM = IDX_W'(NUM_CONST);

    logic [VEC_W-1:0] in_mem    [NUM_IN];
    logic [VEC_W-1:0] tmp_mem   [NUM_TMP];
    logic [VEC_W-1:0] const_mem [NUM_CONST];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            unique case (wr_bank)
                BANK_IN:    if (wr_idx < IN_LIM)    in_mem[wr_idx]    <= wr_vec;
                BANK_TMP:   if (wr_idx < TMP_LIM)   tmp_mem[wr_idx]   <= wr_vec;
                BANK_CONST: if (wr_idx < CONST_LIM) const_mem[wr_idx] <= wr_vec;
                default:    ;
            endcase
        end
    end

    always_comb begin
        rd_vec = '0;
        unique case (rd_bank)
            BANK_IN:    if (rd_idx < IN_LIM)    rd_vec = in_mem[rd_idx];
            BANK_TMP:   if (rd_idx < TMP_LIM)   rd_vec = tmp_mem[rd_idx];
            BANK_CONST: if (rd_idx < CONST_LIM) rd_vec = const_mem[rd_idx];
            default:    rd_vec = '0;
        endcase
    end

endmodule

// File: rtl/srcop_swizzle.sv
module srcop_swizzle #(
    parameter int LANE_W = 24,
    parameter int LANES  = 4,
    parameter logic [LANE_W-1:0] ONE_VAL = 24'h3F0000
) (
    input  logic [LANE_W*LANES-1:0] in_vec,
    input  logic [2*LANES-1:0]      swz,
    input  logic                    force_ones,
    input  logic                    neg,
    output logic [LANE_W*LANES-1:0] out_vec
);
    localparam int SEL_MSB = 2 * LANES - 1;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [1:0]        sel;
        logic [LANE_W-1:0] picked;
        always_comb begin
            sel    = swz[SEL_MSB - 2*k -: 2];
            picked = force_ones ? ONE_VAL : in_vec[LANE_W*sel +: LANE_W];
            out_vec[LANE_W*k +: LANE_W] = {picked[LANE_W-1] ^ neg, picked[LANE_W-2:0]};
        end
    end

endmodule

// File: rtl/srcop_fetch.sv
module srcop_fetch #(
    parameter int LANE_W    = 24,
    parameter int LANES     = 4,
    parameter int SRC_W     = 7,
    parameter int OFS_W     = 10,
    parameter int NUM_IN    = 16,
    parameter int NUM_TMP   = 16,
    parameter int NUM_CONST = 96
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [1:0]                wr_bank,
    input  logic [SRC_W-1:0]          wr_idx,
    input  logic [LANE_W*LANES-1:0]   wr_vec,
    input  logic                      req_valid,
    input  logic [SRC_W-1:0]          req_src,
    input  logic [1:0]                req_isel,
    input  logic [2*LANES-1:0]        req_swz,
    input  logic                      req_neg,
    input  logic [OFS_W-1:0]          addr_x,
    input  logic [OFS_W-1:0]          addr_y,
    input  logic [OFS_W-1:0]          addr_loop,
    output logic                      out_valid,
    output logic [LANE_W*LANES-1:0]   out_vec
);
    import srcop_pkg::*;

    localparam int VEC_W = LANE_W * LANES;

    bank_e              rd_bank;
    logic [SRC_W-1:0]   rd_idx;
    logic               force_ones;
    logic [VEC_W-1:0]   raw_vec;
    logic [VEC_W-1:0]   shaped_vec;
    fetch_state_e       state_q;
    fetch_state_e       state_d;

    srcop_locate #(
        .SRC_W(SRC_W), .OFS_W(OFS_W), .NUM_CONST(NUM_CONST), .BANK_REGS(NUM_IN)
    ) u_locate (
        .src(req_src), .isel(req_isel),
        .ofs_x(addr_x), .ofs_y(addr_y), .ofs_loop(addr_loop),
        .bank(rd_bank), .reg_idx(rd_idx), .force_ones(force_ones)
    );

    srcop_regfile #(
        .VEC_W(VEC_W), .IDX_W(SRC_W),
        .NUM_IN(NUM_IN), .NUM_TMP(NUM_TMP), .NUM_CONST(NUM_CONST)
    ) u_regs (
        .clk(clk), .wr_en(wr_en), .wr_bank(bank_e'(wr_bank)),
        .wr_idx(wr_idx), .wr_vec(wr_vec),
        .rd_bank(rd_bank), .rd_idx(rd_idx), .rd_vec(raw_vec)
    );

    srcop_swizzle #(
        .LANE_W(LANE_W), .LANES(LANES)
    ) u_swz (
        .in_vec(raw_vec), .swz(req_swz), .force_ones(force_ones),
        .neg(req_neg), .out_vec(shaped_vec)
    );

    // Next state: LOAD_REQ, CHAIN_REQ, DRAIN
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = req_valid ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         out_vec <= '0;
        else if (req_valid) out_vec <= shaped_vec;
    end

    assign out_valid = (state_q == ST_SHOW);

endmodule

// File: rtl/srcop_fetch_chk.sv
module srcop_fetch_chk #(
    parameter int LANE_W = 24,
    parameter int LANES  = 4,
    parameter int SRC_W  = 7,
    parameter int OFS_W  = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic [SRC_W-1:0]        req_src,
    input logic [1:0]              req_isel,
    input logic [2*LANES-1:0]      req_swz,
    input logic                    req_neg,
    input logic [OFS_W-1:0]        addr_x,
    input logic                    out_valid,
    input logic [LANE_W*LANES-1:0] out_vec
);
    localparam logic [LANE_W*LANES-1:0] ONES_POS = {LANES{24'h3F0000}};
    localparam logic [LANE_W*LANES-1:0] ONES_NEG = {LANES{24'hBF0000}};

    // R2
    req_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R2
    idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(out_vec));

    // R4
    broadcast_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_swz == 8'h00) |=>
        (out_vec[23:0] == out_vec[47:24] && out_vec[47:24] == out_vec[71:48]
         && out_vec[71:48] == out_vec[95:72]));

    // R9
    past_last_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_src == 7'h7F && req_isel == 2'd1 && addr_x == OFS_W'(1) && !req_neg)
        |=> out_vec == ONES_POS);

    // R10
    past_last_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_src == 7'h7F && req_isel == 2'd1 && addr_x == OFS_W'(1) && req_neg)
        |=> out_vec == ONES_NEG);

    // R1
    always @(posedge clk) begin
        reset_clear_chk: assert (rst_n || (!out_valid && out_vec == '0));
    end

endmodule

bind srcop_fetch srcop_fetch_chk #(
    .LANE_W(LANE_W), .LANES(LANES), .SRC_W(SRC_W), .OFS_W(OFS_W)
) u_chk (.*);

// File: tb/srcop_fetch_test.sv
`timescale 1ns/1ps
module srcop_fetch_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_bank = '0;
    logic [6:0]  wr_idx = '0;
    logic [95:0] wr_vec = '0;
    logic        req_valid = 1'b0;
    logic [6:0]  req_src = '0;
    logic [1:0]  req_isel = '0;
    logic [7:0]  req_swz = 8'h1B;
    logic        req_neg = 1'b0;
    logic [9:0]  addr_x = '0;
    logic [9:0]  addr_y = '0;
    logic [9:0]  addr_loop = '0;
    logic        out_valid;
    logic [95:0] out_vec;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [95:0] m_in [16];
    logic [95:0] m_tmp [16];
    logic [95:0] m_const [96];
    logic [95:0] exp_q [$];
    string       tag_q [$];
    logic [95:0] last_exp = '0;

    always #2.5 clk = ~clk;

    srcop_fetch uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_idx(wr_idx), .wr_vec(wr_vec), .req_valid(req_valid),
        .req_src(req_src), .req_isel(req_isel), .req_swz(req_swz),
        .req_neg(req_neg), .addr_x(addr_x), .addr_y(addr_y),
        .addr_loop(addr_loop), .out_valid(out_valid), .out_vec(out_vec)
    );

    function automatic logic [95:0] pattern(int bank, int idx);
        logic [95:0] v;
        for (int k = 0; k < 4; k++)
            v[24*k +: 24] = {1'b0, 7'(idx), 8'(bank + 8'h50), 6'(k + 5), 2'b01};
        return v;
    endfunction

    function automatic logic [95:0] model(logic [6:0] src, logic [1:0] isel,
                                          logic [7:0] swz, logic neg,
                                          logic [9:0] ax, logic [9:0] ay, logic [9:0] al);
        int ofs;
        logic [95:0] base;
        logic [95:0] r;
        bit ones = 0;
        case (isel)
            2'd1: ofs = int'($signed(ax));
            2'd2: ofs = int'($signed(ay));
            2'd3: ofs = int'($signed(al));
            default: ofs = 0;
        endcase
        if (ofs < -128 || ofs > 127) ofs = 0;
        if (src < 16) base = m_in[src];
        else if (src < 32) base = m_tmp[src - 16];
        else begin
            int e;
            e = ((int'(src) - 32) + ofs) & 127;
            if (e > 95) begin ones = 1; base = '0; end
            else base = m_const[e];
        end
        for (int k = 0; k < 4; k++) begin
            int c;
            logic [23:0] lane;
            c = int'(swz[7-2*k -: 2]);
            lane = ones ? 24'h3F0000 : base[24*c +: 24];
            lane[23] = lane[23] ^ neg;
            r[24*k +: 24] = lane;
        end
        return r;
    endfunction

    task automatic check(string tag, logic [95:0] got, logic [95:0] want);
        n_cmp++;
        if (got !== want) begin
            n_bad++;
            $display("FAIL %s got %h exp %h", tag, got, want);
        end
    endtask

    task automatic do_write(int bank, int idx, logic [95:0] data);
        wr_en = 1'b1; wr_bank = 2'(bank); wr_idx = 7'(idx); wr_vec = data;
        @(negedge clk);
        wr_en = 1'b0;
        if (bank == 0 && idx < 16) m_in[idx] = data;
        else if (bank == 1 && idx < 16) m_tmp[idx] = data;
        else if (bank == 2 && idx < 96) m_const[idx] = data;
    endtask

    task automatic do_req(string tag, logic [6:0] src, logic [1:0] isel, logic [7:0] swz,
                          logic neg, logic [9:0] ax, logic [9:0] ay, logic [9:0] al);
        req_valid = 1'b1; req_src = src; req_isel = isel; req_swz = swz;
        req_neg = neg; addr_x = ax; addr_y = ay; addr_loop = al;
        exp_q.push_back(model(src, isel, swz, neg, ax, ay, al));
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: pop and compare each result strobe
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R2 unexpected strobe got %h exp none", out_vec);
            end else begin
                string t;
                last_exp = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, out_vec, last_exp);
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired got running exp finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset valid", {95'b0, out_valid}, 96'b0);
        check("R1 reset vec", out_vec, 96'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset valid", {95'b0, out_valid}, 96'b0);

        for (int i = 0; i < 16; i++) do_write(0, i, pattern(0, i));
        for (int i = 0; i < 16; i++) do_write(1, i, pattern(1, i));
        for (int i = 0; i < 96; i++) do_write(2, i, pattern(2, i));
        @(negedge clk);

        // R3 bank mapping
        do_req("R3 input v3", 7'h03, 2'd0, 8'h1B, 1'b0, 10'd0, 10'd0, 10'd0);
        do_req("R3 temp r7", 7'h17, 2'd0, 8'h1B, 1'b0, 10'd0, 10'd0, 10'd0);
        do_req("R3 const c0", 7'h20, 2'd0, 8'h1B, 1'b0, 10'd0, 10'd0, 10'd0);
        do_req("R3 const c95", 7'h7F, 2'd0, 8'h1B, 1'b0, 10'd0, 10'd0, 10'd0);
        // R4 swizzles
        do_req("R4 swz yyyy", 7'h12, 2'd0, 8'h55, 1'b0, 10'd0, 10'd0, 10'd0);
        do_req("R4 swz xxxx", 7'h04, 2'd0, 8'h00, 1'b0, 10'd0, 10'd0, 10'd0);
        do_req("R4 swz wwww", 7'h30, 2'd0, 8'hFF, 1'b0, 10'd0, 10'd0, 10'd0);
        do_req("R4 swz wzyx", 7'h09, 2'd0, 8'hE4, 1'b0, 10'd0, 10'd0, 10'd0);
        @(negedge clk);
        // R2 idle: strobe low and value held
        check("R2 idle strobe", {95'b0, out_valid}, 96'b0);
        check("R2 idle hold", out_vec, last_exp);

        // R5 offset sources
        do_req("R5 a0.x c8+2", 7'h28, 2'd1, 8'h1B, 1'b0, 10'd2, 10'd3, 10'd4);
        do_req("R5 a0.y c8+3", 7'h28, 2'd2, 8'h1B, 1'b0, 10'd2, 10'd3, 10'd4);
        do_req("R5 aL c8+4", 7'h28, 2'd3, 8'h1B, 1'b0, 10'd2, 10'd3, 10'd4);
        do_req("R5 negative c10-3", 7'h2A, 2'd1, 8'h1B, 1'b0, -10'sd3, 10'd0, 10'd0);
        // R6 offset ignored on input and temp
        do_req("R6 input v5 ofs", 7'h05, 2'd1, 8'h1B, 1'b0, 10'd4, 10'd0, 10'd0);
        do_req("R6 temp r2 ofs", 7'h12, 2'd3, 8'h1B, 1'b0, 10'd0, 10'd0, 10'd7);
        // R7 out of byte range
        do_req("R7 ofs 200", 7'h25, 2'd1, 8'h1B, 1'b0, 10'd200, 10'd0, 10'd0);
        do_req("R7 ofs -129", 7'h25, 2'd2, 8'h1B, 1'b0, 10'd0, -10'sd129, 10'd0);
        do_req("R7 ofs 128", 7'h25, 2'd3, 8'h1B, 1'b0, 10'd0, 10'd0, 10'd128);
        // R8 wrap
        do_req("R8 c0-128", 7'h20, 2'd1, 8'h1B, 1'b0, -10'sd128, 10'd0, 10'd0);
        do_req("R8 c95-128", 7'h7F, 2'd1, 8'h1B, 1'b0, -10'sd128, 10'd0, 10'd0);
        do_req("R8 c50+100", 7'h52, 2'd1, 8'h1B, 1'b0, 10'd100, 10'd0, 10'd0);
        do_req("R8 c3-10", 7'h23, 2'd2, 8'h1B, 1'b0, 10'd0, -10'sd10, 10'd0);
        // R9 beyond last constant
        do_req("R9 c95+1", 7'h7F, 2'd1, 8'h1B, 1'b0, 10'd1, 10'd0, 10'd0);
        do_req("R9 c0+127", 7'h20, 2'd1, 8'h55, 1'b0, 10'd127, 10'd0, 10'd0);
        do_req("R9 c90+10", 7'h7A, 2'd3, 8'h1B, 1'b0, 10'd0, 10'd0, 10'd10);
        // R10 negation
        do_req("R10 neg v2", 7'h02, 2'd0, 8'h1B, 1'b1, 10'd0, 10'd0, 10'd0);
        do_req("R10 neg swz r9", 7'h19, 2'd0, 8'hE4, 1'b1, 10'd0, 10'd0, 10'd0);
        do_req("R10 neg ones", 7'h7F, 2'd1, 8'h1B, 1'b1, 10'd1, 10'd0, 10'd0);
        @(negedge clk);

        // R10 negating a negative lane clears its sign
        do_write(0, 6, {24'h812345, 24'h400000, 24'h9F0001, 24'h000002});
        do_req("R10 neg of negative", 7'h06, 2'd0, 8'h1B, 1'b1, 10'd0, 10'd0, 10'd0);

        // R11 ignored writes
        do_write(3, 4, {4{24'h777777}});
        do_write(0, 20, {4{24'h666666}});
        do_write(1, 100, {4{24'h555555}});
        do_req("R11 bank3 write ignored", 7'h04, 2'd0, 8'h1B, 1'b0, 10'd0, 10'd0, 10'd0);
        do_req("R11 input idx20 ignored", 7'h14, 2'd0, 8'h1B, 1'b0, 10'd0, 10'd0, 10'd0);
        do_req("R11 const c4 intact", 7'h24, 2'd0, 8'h1B, 1'b0, 10'd0, 10'd0, 10'd0);
        repeat (3) @(negedge clk);
        check("R2 queue drained", 96'(exp_q.size()), 96'd0);
        check("R2 final idle strobe", {95'b0, out_valid}, 96'b0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule